// File: doc/BRIEF.md
# Warning Reporter with Pulsed Fault Pin

This block watches a vector of warning conditions and keeps one sticky status bit for each of them. A warning only reports: it never changes anything else in the system. While at least one warning is raised and has not yet been acknowledged, the active-low fault pin toggles with a fixed pattern. The pattern is a low phase of a set length followed by a high phase of the same length, and it repeats. If no warning is waiting, the pin stays high.

Software acknowledges a warning by reading its status bit. The read arrives as a strobe together with a bit index. Once acknowledged, a warning no longer drives the pin, but its status bit stays set for as long as its condition is present. A warning drives the pin again only after its condition has gone away and then returned. If the condition has already gone by the time of the read, the read returns the warning to its rest state and the status bit clears.

Each warning has its own small state machine with three states: rest, waiting for acknowledge, and acknowledged-but-still-present. A shared phase timer produces the pin pattern. The length of one phase is a parameter counted in clock cycles.

Top module: `warn_reporter`

## Requirements
- R1: After synchronous reset, all status bits are 0 and the fault pin is 1.
- R2: A warning in rest whose condition input is high at a clock edge shows status 1 after that edge and becomes waiting.
- R3: The fault pin goes low on the edge after the first warning becomes waiting. It then stays low for HALF_CYC cycles and high for HALF_CYC cycles, repeating while any warning is waiting.
- R4: A read strobe whose index equals a waiting warning's bit, while its condition is high, acknowledges it. Its status stays 1 and it stops driving the pin, so the pin is 1 one cycle later if nothing else is waiting.
- R5: An acknowledged warning's status clears on the edge at which its condition input is sampled low.
- R6: An acknowledged warning whose condition stays high never drives the pin again. After its condition has been low and then high again, it becomes waiting and pulses the pin again.
- R7: A waiting warning's status stays 1 when its condition drops, until it is read.
- R8: A read of a waiting warning whose condition is low returns it to rest, and its status reads 0 after that edge.
- R9: A read of a warning in rest or already acknowledged has no effect. A read index at or above NUM_WARN matches no warning.
- R10: While no warning is waiting, the fault pin is 1 and the phase timer is cleared, so the next waiting warning starts with a full low phase.
- R11: The pin pulses while any warning is waiting. Acknowledging one of several waiting warnings does not stop the pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warn_in | input | NUM_WARN | Warning condition inputs, one per warning |
| rd_en | input | 1 | Status read strobe (acts as acknowledge) |
| rd_idx | input | IDX_W | Bit index of the status bit being read |
| warn_status | output | NUM_WARN | Sticky status bit per warning |
| fault_n | output | 1 | Active-low pulsed fault pin |

## Verification
The hardest case to reach from the ports is an ordering of events on the same warning that are spaced far apart. One example is a condition that drops while the warning is still waiting, followed by a read some cycles later. Another is a re-assertion after an acknowledge, arriving while a second warning keeps the pattern running in the middle of a phase. Directed sequences build these orderings explicitly, using a short phase length. A long random run then flips individual conditions rarely and issues reads to random indices, including out-of-range ones. A cycle-level reference model written from the requirements is compared on every cycle.

// File: rtl/warn_pkg.sv
package warn_pkg;
  typedef enum logic [1:0] {
    WS_REST = 2'd0,
    WS_WAIT = 2'd1,
    WS_ACKD = 2'd2
  } warn_state_t;
endpackage

// File: rtl/warn_bit_fsm.sv
module warn_bit_fsm
  import warn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic rd_hit,
  output logic status,
  output logic waiting
);
  warn_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WS_REST: if (cond) st_d = WS_WAIT;
      WS_WAIT: if (rd_hit) st_d = cond ? WS_ACKD : WS_REST;
      WS_ACKD: if (!cond) st_d = WS_REST;
      default: st_d = WS_REST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= WS_REST;
    else     st_q <= st_d;
  end

  assign status  = (st_q != WS_REST);
  assign waiting = (st_q == WS_WAIT);

  a_r7_wait_sticky: assert property (@(posedge clk) disable iff (rst)
    (st_q == WS_WAIT && !rd_hit) |=> (st_q == WS_WAIT));
  a_r4_ack_keeps_status: assert property (@(posedge clk) disable iff (rst)
    (st_q == WS_WAIT && rd_hit && cond) |=> (status && !waiting));
  a_r8_read_gone_clears: assert property (@(posedge clk) disable iff (rst)
    (st_q == WS_WAIT && rd_hit && !cond) |=> !status);
  a_r5_ackd_release: assert property (@(posedge clk) disable iff (rst)
    (st_q == WS_ACKD && !cond) |=> !status);
  a_r6_ackd_no_rewait: assert property (@(posedge clk) disable iff (rst)
    (st_q == WS_ACKD) |=> !waiting);
endmodule

// File: rtl/warn_pulse_gen.sv
module warn_pulse_gen #(
  parameter int HALF_CYC = 2800
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic fault_n
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          pin_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      pin_q <= 1'b1;
    end else if (!run_q) begin
      cnt_q <= '0;
      run_q <= 1'b1;
      pin_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      pin_q <= ~pin_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fault_n = pin_q;

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (active && run_q && cnt_q != LAST) |=> $stable(pin_q));
endmodule

// File: rtl/warn_reporter.sv
module warn_reporter
  import warn_pkg::*;
#(
  parameter int NUM_WARN = 6,
  parameter int HALF_CYC = 2800,
  parameter int IDX_W    = (NUM_WARN > 1) ? $clog2(NUM_WARN) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_WARN-1:0] warn_in,
  input  logic                rd_en,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [NUM_WARN-1:0] warn_status,
  output logic                fault_n
);
  logic [NUM_WARN-1:0] wait_vec;
  logic                any_wait;

  for (genvar g = 0; g < NUM_WARN; g++) begin : g_bit
    logic hit;
    assign hit = rd_en && (rd_idx == IDX_W'(g));
    warn_bit_fsm u_fsm (
      .clk    (clk),
      .rst    (rst),
      .cond   (warn_in[g]),
      .rd_hit (hit),
      .status (warn_status[g]),
      .waiting(wait_vec[g])
    );
  end

  assign any_wait = |wait_vec;

  warn_pulse_gen #(.HALF_CYC(HALF_CYC)) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .active (any_wait),
    .fault_n(fault_n)
  );

  a_r3_first_low: assert property (@(posedge clk) disable iff (rst)
    $rose(any_wait) |=> !fault_n);
  a_r10_rest_high: assert property (@(posedge clk) disable iff (rst)
    !any_wait |=> fault_n);
  a_r2_wait_has_status: assert property (@(posedge clk) disable iff (rst)
    (wait_vec & ~warn_status) == '0);
endmodule

// File: tb/warn_reporter_test.sv
module warn_reporter_test;
  localparam int N  = 6;
  localparam int H  = 5;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  warn_in = '0;
  logic          rd_en = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [N-1:0]  warn_status;
  logic          fault_n;

  int n_chk = 0, n_bad = 0;
  int m_st [N];
  bit m_run, m_pin;
  int m_cnt;

  always #10 clk = ~clk;

  warn_reporter #(.NUM_WARN(N), .HALF_CYC(H), .IDX_W(IW)) uut (
    .clk(clk), .rst(rst), .warn_in(warn_in), .rd_en(rd_en),
    .rd_idx(rd_idx), .warn_status(warn_status), .fault_n(fault_n));

  // state codes of the model: 0 rest, 1 waiting, 2 acknowledged
  function automatic int nxt(int s, bit c, bit hit);
    if (s == 0) return c ? 1 : 0;
    if (s == 1) return hit ? (c ? 2 : 0) : 1;
    return c ? 2 : 0;
  endfunction

  function automatic logic [N-1:0] exp_status();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (m_st[i] != 0);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(logic [N-1:0] c, bit rd, logic [IW-1:0] idx);
    bit anyw;
    warn_in = c; rd_en = rd; rd_idx = idx;
    anyw = 0;
    for (int i = 0; i < N; i++) if (m_st[i] == 1) anyw = 1;
    if (!anyw) begin m_pin = 1; m_run = 0; m_cnt = 0; end
    else if (!m_run) begin m_pin = 0; m_run = 1; m_cnt = 0; end
    else if (m_cnt == H - 1) begin m_pin = ~m_pin; m_cnt = 0; end
    else m_cnt++;
    for (int i = 0; i < N; i++)
      m_st[i] = nxt(m_st[i], c[i], rd && (int'(idx) == i));
    @(posedge clk);
    @(negedge clk);
    chk("R11 model status", 32'(warn_status), 32'(exp_status()));
    chk("R3 model pin", 32'(fault_n), 32'(m_pin));
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [N-1:0] cv;
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) m_st[i] = 0;
    m_run = 0; m_pin = 1; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 status after reset", 32'(warn_status), 0);
    chk("R1 pin after reset", 32'(fault_n), 1);

    // R2 / R3: raise bit 0
    cyc(6'b000001, 0, 0);
    chk("R2 status set", 32'(warn_status), 32'h1);
    chk("R3 pin still high at set edge", 32'(fault_n), 1);
    for (int k = 0; k < 3 * H; k++) begin
      cyc(6'b000001, 0, 0);
      chk("R3 pulse shape", 32'(fault_n), 32'(((k / H) % 2) == 1));
    end
    // R4: acknowledge with condition present
    cyc(6'b000001, 1, 0);
    chk("R4 status kept after ack", 32'(warn_status), 32'h1);
    cyc(6'b000001, 0, 0);
    chk("R4 pin released", 32'(fault_n), 1);
    // R6 / R9: stays quiet; second read no effect
    for (int k = 0; k < 2 * H; k++) begin
      cyc(6'b000001, (k == 2), 0);
      chk("R6 no re-report while held", 32'(fault_n), 1);
    end
    chk("R9 read of acked no effect", 32'(warn_status), 32'h1);
    // R5: condition drops
    cyc(6'b000000, 0, 0);
    chk("R5 status clears", 32'(warn_status), 0);
    chk("R10 pin high idle", 32'(fault_n), 1);
    // R6: recurrence re-reports
    cyc(6'b000001, 0, 0);
    cyc(6'b000000, 0, 0);
    chk("R6 re-report pin low", 32'(fault_n), 0);
    // R7: sticky while waiting after drop
    repeat (H + 2) cyc(6'b000000, 0, 0);
    chk("R7 status sticky", 32'(warn_status), 32'h1);
    // R8: read with condition gone
    cyc(6'b000000, 1, 0);
    chk("R8 status cleared by read", 32'(warn_status), 0);
    cyc(6'b000000, 0, 0);
    chk("R10 pin back high", 32'(fault_n), 1);
    // R9: out-of-range index and read of resting bit
    cyc(6'b000010, 1, 3'd7);
    cyc(6'b000010, 1, 3'd6);
    cyc(6'b000010, 1, 3'd4);
    chk("R9 out of range read ignored", 32'(warn_status), 32'h2);
    // R11: two waiting, ack one
    cyc(6'b100010, 0, 0);
    cyc(6'b100010, 1, 3'd1);
    chk("R11 one acked", 32'(warn_status), 32'h22);
    for (int k = 0; k < 2 * H + 1; k++) cyc(6'b100010, 0, 0);
    chk("R11 still pulsing phase", 32'(m_run), 1);
    cyc(6'b100010, 1, 3'd5);
    cyc(6'b000000, 0, 0);
    chk("R10 all quiet pin high", 32'(fault_n), 1);
    chk("R5 both cleared", 32'(warn_status), 0);

    // random phase
    cv = '0;
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < N; i++)
        if (($urandom % 16) == 0) cv[i] = ~cv[i];
      cyc(cv, (($urandom % 4) == 0), IW'($urandom % 8));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule